// File: doc/BRIEF.md
# Refresh Command Timing Guard

This block sits in a memory controller that drives an eight-bank LPDDR2-style device. It decides, cycle by cycle, whether a single-bank refresh or an all-bank refresh may be issued. It also decides whether an ACTIVATE may go to each of the eight banks. The controller reports every command it issues on strobe inputs: ACTIVATE and PRECHARGE carry a bank number, and PRECHARGE can also cover all banks.

The guard keeps a copy of the device's round-robin refresh pointer, an open/closed flag for each bank, and four saturating down-counters. The counters enforce the all-bank refresh cycle, the single-bank refresh cycle, the activate-to-activate spacing and the precharge time. Each separation is a parameter given in clock cycles. The guard also supplies the command-address code for the refresh type being requested. It raises a sticky flag when a refresh strobe arrives while that refresh is not allowed, and such a strobe is otherwise ignored.

Top module: `refresh_guard`

## Requirements
- R1: While rstN is low and in the first cycle after it, refPbOk, refAbOk and every actOk bit are 1, nextBank is 0 and violation is 0.
- R2: refCa presents {CA3,CA2,CA1,CA0}. It reads 4'b1100 while cmdRefAb is high, otherwise 4'b0100 (the single-bank code). The output is combinational from the inputs.
- R3: Each accepted single-bank refresh moves nextBank one step through 0,1,…,7 and wraps from 7 to 0.
- R4: After an edge where devReset or srExit is high, or where an all-bank refresh is accepted, nextBank is 0. These events take priority over a single-bank refresh accepted at the same edge.
- R5: After an accepted single-bank refresh at edge e, both refresh oks and the ACTIVATE ok of the refreshed bank stay low until edge e+TRFCPB. ACTIVATE to any other bank is allowed again from edge e+TRRD.
- R6: After an accepted all-bank refresh at edge e, refPbOk, refAbOk and all actOk bits stay low until edge e+TRFCAB.
- R7: An ACTIVATE at edge e marks its bank open. refAbOk goes low, and refPbOk and every actOk stay low until edge e+TRRD.
- R8: A PRECHARGE at edge e closes its bank, or all banks when preAll is 1. refAbOk stays low until edge e+TRP.
- R9: A refresh strobe that arrives while its ok is low, or while both refresh strobes are high, sets violation. violation stays set until reset. The strobe moves neither the pointer nor any timer.
- R10: refPbOk depends only on the bank named by nextBank. Other banks may be open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdAct | input | 1 | ACTIVATE issued this cycle |
| actBank | input | 3 | Bank of the ACTIVATE |
| cmdPre | input | 1 | PRECHARGE issued this cycle |
| preAll | input | 1 | PRECHARGE covers all banks |
| preBank | input | 3 | Bank of a single-bank PRECHARGE |
| cmdRefPb | input | 1 | Single-bank refresh requested this cycle |
| cmdRefAb | input | 1 | All-bank refresh requested this cycle |
| devReset | input | 1 | Device RESET command issued |
| srExit | input | 1 | Self-refresh exit |
| refPbOk | output | 1 | Single-bank refresh is legal now |
| refAbOk | output | 1 | All-bank refresh is legal now |
| actOk | output | 8 | ACTIVATE is legal to each bank |
| nextBank | output | 3 | Target of the next single-bank refresh |
| refCa | output | 4 | Refresh command-address code {CA3,CA2,CA1,CA0} |
| violation | output | 1 | Sticky illegal-refresh flag |

## Verification
Every command is sampled on a rising edge. The oks, nextBank and violation change in the cycle after that edge. refCa follows cmdRefAb in the same cycle. A timer loaded at edge e releases its ok for the command at edge e+N, so a separation of N cycles is legal exactly N edges later.

The bench drives inputs just after each rising edge. A behavioural model updates at the same edge from edge indices and the recorded edge of each last command. All outputs are compared at the falling edge, where each of these delays has already taken effect. Directed checks sit at the first cycle a separation ends.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int BANKS  = 8;
  localparam int BANK_W = $clog2(BANKS);
  localparam int NUM_TMR = 4;
  localparam int T_AB  = 0;
  localparam int T_PB  = 1;
  localparam int T_RRD = 2;
  localparam int T_RP  = 3;

  typedef struct packed {
    logic acceptPb;
    logic acceptAb;
    logic syncPtr;
    logic setViol;
  } rgStrobe_t;

  function automatic int maxOf4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/rg_downcnt.sv
module rg_downcnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         zero
);
  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (load)          count <= loadVal;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/rg_dp.sv
module rg_dp
  import rg_pkg::*;
#(
  parameter int TRFCAB = 20,
  parameter int TRFCPB = 9,
  parameter int TRRD   = 3,
  parameter int TRP    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rgStrobe_t         strb,
  input  logic              cmdAct,
  input  logic [BANK_W-1:0] actBank,
  input  logic              cmdPre,
  input  logic              preAll,
  input  logic [BANK_W-1:0] preBank,
  output logic [NUM_TMR-1:0] tmrZero,
  output logic [BANKS-1:0]  bankActive,
  output logic [BANK_W-1:0] ptr,
  output logic [BANK_W-1:0] pbBank,
  output logic              violation
);
  localparam int MAXV = maxOf4(TRFCAB, TRFCPB, TRRD, TRP);
  localparam int TW   = $clog2(MAXV + 1);
  localparam int LIM [NUM_TMR] = '{TRFCAB, TRFCPB, TRRD, TRP};

  logic [NUM_TMR-1:0] tmrLoad;

  always_comb begin
    tmrLoad        = '0;
    tmrLoad[T_AB]  = strb.acceptAb;
    tmrLoad[T_PB]  = strb.acceptPb;
    tmrLoad[T_RRD] = strb.acceptPb | cmdAct;
    tmrLoad[T_RP]  = cmdPre;
  end

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      rg_downcnt #(.W(TW)) u_cnt (
        .clk     (clk),
        .rstN    (rstN),
        .load    (tmrLoad[i]),
        .loadVal (TW'(LIM[i] - 1)),
        .zero    (tmrZero[i])
      );
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rstN)
          bankActive[b] <= 1'b0;
        else if (cmdAct && actBank == BANK_W'(b))
          bankActive[b] <= 1'b1;
        else if (cmdPre && (preAll || preBank == BANK_W'(b)))
          bankActive[b] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      pbBank    <= '0;
      violation <= 1'b0;
    end else begin
      if (strb.syncPtr || strb.acceptAb) ptr <= '0;
      else if (strb.acceptPb)            ptr <= ptr + 1'b1;
      if (strb.acceptPb) pbBank <= ptr;
      if (strb.setViol)  violation <= 1'b1;
    end
  end

  // R3
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptPb && !strb.syncPtr) |=> ptr == BANK_W'($past(ptr) + 1'b1));
  // R4
  ptr_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.syncPtr || strb.acceptAb) |=> ptr == '0);
  // R9
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);
  // R8
  rp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPre && TRP > 1) |=> !tmrZero[T_RP]);
  // R7
  rrd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAct && TRRD > 1) |=> !tmrZero[T_RRD]);
endmodule

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import rg_pkg::*;
#(
  parameter int TRFCAB = 20,
  parameter int TRFCPB = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdRefPb,
  input  logic               cmdRefAb,
  input  logic               devReset,
  input  logic               srExit,
  input  logic [NUM_TMR-1:0] tmrZero,
  input  logic [BANKS-1:0]   bankActive,
  input  logic [BANK_W-1:0]  ptr,
  input  logic [BANK_W-1:0]  pbBank,
  output rgStrobe_t          strb,
  output logic               refPbOk,
  output logic               refAbOk,
  output logic [BANKS-1:0]   actOk,
  output logic [3:0]         refCa
);
  logic refreshGap;

  // refresh-to-refresh separations shared by both refresh types
  assign refreshGap = tmrZero[T_AB] & tmrZero[T_PB];
  assign refPbOk = refreshGap & tmrZero[T_RRD] & ~bankActive[ptr];
  assign refAbOk = refreshGap & tmrZero[T_RP] & ~(|bankActive);

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_act
      assign actOk[b] = ~bankActive[b] & tmrZero[T_AB] & tmrZero[T_RRD]
                      & (tmrZero[T_PB] | (pbBank != BANK_W'(b)));
    end
  endgenerate

  always_comb begin
    strb.acceptPb = cmdRefPb & ~cmdRefAb & refPbOk;
    strb.acceptAb = cmdRefAb & ~cmdRefPb & refAbOk;
    strb.syncPtr  = devReset | srExit;
    strb.setViol  = (cmdRefPb | cmdRefAb) & ~(strb.acceptPb | strb.acceptAb);
  end

  // CA0 low, CA1 low, CA2 high; CA3 picks the refresh type
  assign refCa = {cmdRefAb, 1'b1, 2'b00};

  // R5
  pb_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptPb && TRFCPB > 1) |=> (!refPbOk && !refAbOk));
  // R6
  ab_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.acceptAb && TRFCAB > 1) |=> (actOk == '0 && !refPbOk && !refAbOk));
  // R9
  one_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.acceptPb, strb.acceptAb, strb.setViol}) <= 1);
endmodule

// File: rtl/refresh_guard.sv
module refresh_guard
  import rg_pkg::*;
#(
  parameter int TRFCAB = 20,
  parameter int TRFCPB = 9,
  parameter int TRRD   = 3,
  parameter int TRP    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdAct,
  input  logic [BANK_W-1:0] actBank,
  input  logic              cmdPre,
  input  logic              preAll,
  input  logic [BANK_W-1:0] preBank,
  input  logic              cmdRefPb,
  input  logic              cmdRefAb,
  input  logic              devReset,
  input  logic              srExit,
  output logic              refPbOk,
  output logic              refAbOk,
  output logic [BANKS-1:0]  actOk,
  output logic [BANK_W-1:0] nextBank,
  output logic [3:0]        refCa,
  output logic              violation
);
  rgStrobe_t          strb;
  logic [NUM_TMR-1:0] tmrZero;
  logic [BANKS-1:0]   bankActive;
  logic [BANK_W-1:0]  pbBank;

  rg_ctrl #(.TRFCAB(TRFCAB), .TRFCPB(TRFCPB)) u_ctrl (
    .clk, .rstN, .cmdRefPb, .cmdRefAb, .devReset, .srExit,
    .tmrZero, .bankActive, .ptr(nextBank), .pbBank,
    .strb, .refPbOk, .refAbOk, .actOk, .refCa
  );

  rg_dp #(.TRFCAB(TRFCAB), .TRFCPB(TRFCPB), .TRRD(TRRD), .TRP(TRP)) u_dp (
    .clk, .rstN, .strb, .cmdAct, .actBank, .cmdPre, .preAll, .preBank,
    .tmrZero, .bankActive, .ptr(nextBank), .pbBank, .violation
  );
endmodule

// File: tb/test_refresh_guard.sv
`timescale 1ns/1ps
module test_refresh_guard;
  localparam int TRFCAB = 20, TRFCPB = 9, TRRD = 3, TRP = 4;

  logic clk = 0, rstN = 0;
  logic cmdAct = 0, cmdPre = 0, preAll = 0, cmdRefPb = 0, cmdRefAb = 0;
  logic devReset = 0, srExit = 0;
  logic [2:0] actBank = 0, preBank = 0;
  logic refPbOk, refAbOk, violation;
  logic [7:0] actOk;
  logic [2:0] nextBank;
  logic [3:0] refCa;

  int checks = 0, failures = 0;
  bit cmpOn = 0;

  refresh_guard #(.TRFCAB(TRFCAB), .TRFCPB(TRFCPB), .TRRD(TRRD), .TRP(TRP)) i_refresh_guard (
    .clk, .rstN, .cmdAct, .actBank, .cmdPre, .preAll, .preBank, .cmdRefPb, .cmdRefAb,
    .devReset, .srExit, .refPbOk, .refAbOk, .actOk, .nextBank, .refCa, .violation);

  always #2.5 clk = ~clk;

  // behavioural reference model in edge indices
  int cyc, lastAb, lastPb, lastAct, lastPre, lastPbBank, mPtr;
  bit mViol;
  bit [7:0] mOpen;

  function automatic bit expPb();
    return (cyc - lastAb >= TRFCAB) && (cyc - lastPb >= TRFCPB) &&
           (cyc - lastAct >= TRRD) && !mOpen[mPtr];
  endfunction
  function automatic bit expAb();
    return (cyc - lastAb >= TRFCAB) && (cyc - lastPb >= TRFCPB) &&
           (cyc - lastPre >= TRP) && (mOpen == 0);
  endfunction
  function automatic bit [7:0] expAct();
    bit [7:0] v;
    for (int b = 0; b < 8; b++)
      v[b] = !mOpen[b] && (cyc - lastAb >= TRFCAB) && (cyc - lastAct >= TRRD) &&
             (cyc - lastPb >= TRRD) && (b != lastPbBank || cyc - lastPb >= TRFCPB);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; lastAb = -1000; lastPb = -1000; lastAct = -1000; lastPre = -1000;
      lastPbBank = -1; mPtr = 0; mViol = 0; mOpen = 0;
    end else begin
      bit accPb, accAb;
      accPb = cmdRefPb && !cmdRefAb && expPb();
      accAb = cmdRefAb && !cmdRefPb && expAb();
      if ((cmdRefPb || cmdRefAb) && !(accPb || accAb)) mViol = 1;
      if (accPb) begin lastPb = cyc; lastPbBank = mPtr; end
      if (accAb) lastAb = cyc;
      if (cmdPre) begin
        lastPre = cyc;
        if (preAll) mOpen = 0; else mOpen[preBank] = 0;
      end
      if (cmdAct) begin lastAct = cyc; mOpen[actBank] = 1; end
      if (devReset || srExit || accAb) mPtr = 0;
      else if (accPb) mPtr = (mPtr + 1) % 8;
      cyc++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN && cmpOn) begin
    chk(refPbOk == expPb(), "R5 R7 R10 refPbOk", refPbOk, expPb());
    chk(refAbOk == expAb(), "R6 R8 refAbOk", refAbOk, expAb());
    chk(actOk == expAct(), "R5 R6 R7 actOk", actOk, expAct());
    chk(nextBank == mPtr[2:0], "R3 R4 nextBank", nextBank, mPtr);
    chk(violation == mViol, "R9 violation", violation, mViol);
    chk(refCa == (cmdRefAb ? 4'b1100 : 4'b0100), "R2 refCa", refCa, cmdRefAb ? 12 : 4);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic clr();
    cmdAct = 0; cmdPre = 0; preAll = 0; cmdRefPb = 0; cmdRefAb = 0;
    devReset = 0; srExit = 0;
  endtask
  // assumes call right after posedge+1; command is sampled at next edge
  task automatic step();
    @(posedge clk); #1; clr();
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    chk(refPbOk && refAbOk && actOk == 8'hFF && nextBank == 0 && !violation,
        "R1 reset", {refPbOk, refAbOk, actOk, nextBank, violation}, 13'h1FF0);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    chk(refPbOk && refAbOk && actOk == 8'hFF && nextBank == 0, "R1 first cycle",
        {refPbOk, refAbOk, actOk, nextBank}, 12'h3FF << 3 >> 3);
    cmpOn = 1;
    @(posedge clk); #1;
    // R2 and R6: legal all-bank refresh
    cmdRefAb = 1;
    @(negedge clk);
    chk(refCa == 4'b1100, "R2 all-bank code", refCa, 12);
    step();
    @(negedge clk);
    chk(actOk == 0 && !refPbOk, "R6 blocked after all-bank", actOk, 0);
    idle(TRFCAB - 2);
    @(negedge clk);
    chk(!refPbOk, "R6 one cycle early", refPbOk, 0);
    idle(1);
    @(negedge clk);
    chk(refPbOk && actOk == 8'hFF, "R6 released", actOk, 255);
    // R3: walk the pointer through a wrap
    for (int k = 0; k < 9; k++) begin
      cmdRefPb = 1;
      @(negedge clk);
      chk(refCa == 4'b0100, "R2 single-bank code", refCa, 4);
      step();
      @(negedge clk);
      chk(nextBank == 3'((k + 1) % 8), "R3 pointer step", nextBank, (k + 1) % 8);
      if (k == 0) chk(actOk[0] == 0 && actOk[3] == 0, "R5 rrd window", actOk, 0);
      idle(TRRD - 1);
      @(negedge clk);
      if (k == 0) chk(actOk[0] == 0 && actOk[3] == 1, "R5 other bank free", actOk, 8'hFE);
      idle(TRFCPB - TRRD);
    end
    // R7 and R10: pointer now at 1
    actBank = 1; cmdAct = 1; step();
    @(negedge clk);
    chk(!refAbOk && !actOk[1], "R7 bank 1 open", {refAbOk, actOk[1]}, 0);
    idle(TRRD);
    @(negedge clk);
    chk(!refPbOk, "R10 target open", refPbOk, 0);
    actBank = 5; cmdAct = 1; step();
    preBank = 1; cmdPre = 1; idle(TRRD - 1); step();
    idle(1);
    @(negedge clk);
    chk(refPbOk && !refAbOk, "R10 other bank open", {refPbOk, refAbOk}, 2);
    // R8
    preAll = 1; cmdPre = 1; step();
    idle(TRP - 2);
    @(negedge clk);
    chk(!refAbOk, "R8 precharge window", refAbOk, 0);
    idle(1);
    @(negedge clk);
    chk(refAbOk, "R8 released", refAbOk, 1);
    // R4: sync wins over a same-edge single-bank refresh
    cmdRefPb = 1; devReset = 1; step();
    @(negedge clk);
    chk(nextBank == 0, "R4 reset command", nextBank, 0);
    idle(TRFCPB);
    cmdRefPb = 1; step();
    srExit = 1; step();
    @(negedge clk);
    chk(nextBank == 0, "R4 self-refresh exit", nextBank, 0);
    // R9: illegal strobe right after a refresh
    idle(TRFCPB);
    cmdRefPb = 1; step();
    cmdRefPb = 1; step();
    @(negedge clk);
    chk(violation && nextBank == 1, "R9 rejected strobe", {violation, nextBank}, 9);
    idle(3);
    @(negedge clk);
    chk(violation, "R9 sticky", violation, 1);
    // mixed stimulus, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 12;
      case (r)
        0, 1: begin cmdAct = 1; actBank = 3'($urandom); end
        2, 3: begin cmdPre = 1; preAll = ($urandom % 3 == 0); preBank = 3'($urandom); end
        4, 5, 6: cmdRefPb = expPb() || ($urandom % 8 == 0);
        7, 8: cmdRefAb = expAb() || ($urandom % 8 == 0);
        9: begin srExit = ($urandom % 2 == 0); devReset = !srExit; end
        default: ;
      endcase
      step();
    end
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule